// File: doc/BRIEF.md
# Stereo Peak Limiter Gain Controller

This block decides, once per audio frame, how much of the programmed tone boost and user attenuation a stereo playback path may apply without the output clipping. It sits after the tone equaliser, which works with headroom bits above the 24-bit output range. On each frame strobe it inspects the left and right equalised samples. When either one falls outside the 24-bit signed range, the block treats the frame as clipping.

Gain is taken away in a fixed order. Bass and treble boost are given back first, one dB at a time, and only when both are at zero does the block add digital attenuation. Recovery runs in the opposite order: the extra attenuation is removed first, then the boost is restored. Neither ever goes past what the user programmed. A clipping frame and a clean frame each drive their own frame counter, so the attack and release step rates are set independently in frame periods. One common gain is produced for both channels, which keeps the stereo image.

The outputs are the effective bass code, the effective treble code and the effective attenuation. The equaliser and the converter downstream apply these values.

Top module: `peak_limiter`

## Requirements
- R1: A frame clips when the left or the right sample is outside the range -8388608 to +8388607. Samples are IN_W-bit two's complement, and the test is made only on a cycle with frame_stb high.
- R2: A reduction step lowers each effective boost (bass, treble) that is above 0 by one code (1 dB). Attenuation rises by one code only when both effective boosts are already 0.
- R3: A reduction step happens on the Nth consecutive clipping frame counted since the last step or the last clean frame. N is the attack_rate code, and code 0 means 128.
- R4: A recovery step happens on the Nth consecutive clean frame counted since the last step or the last clipping frame. N is the release_rate code, and code 0 means 128.
- R5: While lim_en is 0, all reductions and both frame counters are cleared. The outputs then equal the user settings, and clipping frames have no effect.
- R6: A recovery step first lowers the added attenuation by one code. Only when no attenuation is added does it raise each reduced boost by one code. No output ever exceeds its user setting.
- R7: A clip on only one channel reduces the common gain that both channels use.
- R8: Boost codes are in dB from 0 to 12, and a setting above 12 acts as 12. An effective boost is the clamped setting minus the reduction, and never goes below 0.
- R9: Effective attenuation, in dB, is the user setting plus the added attenuation, limited to ATT_MAX (96).
- R10: The reductions change only on a cycle with frame_stb high, or when lim_en is 0. The outputs follow the new state in the cycle after the strobe edge.
- R11: After reset no reduction is held, and the outputs equal the user settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lim_en | input | 1 | Limiter enable |
| frame_stb | input | 1 | One-cycle pulse per audio frame; samples valid |
| smp_l | input | IN_W (28) | Left equalised sample, two's complement |
| smp_r | input | IN_W (28) | Right equalised sample, two's complement |
| bass_set | input | 4 | User bass boost, dB |
| treble_set | input | 4 | User treble boost, dB |
| atten_set | input | 7 | User attenuation, dB |
| attack_rate | input | 7 | Clipping frames per reduction step (0 = 128) |
| release_rate | input | 7 | Clean frames per recovery step (0 = 128) |
| bass_eff | output | 4 | Effective bass boost, dB |
| treble_eff | output | 4 | Effective treble boost, dB |
| atten_eff | output | 7 | Effective attenuation, dB |

## Verification
A sequence of frames exercises every stage of limiting. Samples sit exactly on each edge of full scale and one step beyond it, so an off-by-one in the range test shows up. Clips on the left only and on the right only show that either channel alone reduces the common gain. A long clipping run followed by a clean run shows the order in which boost and attenuation move, both on the way down and on the way up. A release code of 2 separates the frames that step from those that do not. Directed cases cover a strobe-free stretch, a disable, an out-of-range boost setting, the attenuation ceiling, and an attack code of 0 over 128 frames.

// File: rtl/lim_pkg.sv
package lim_pkg;
  localparam int BOOST_W   = 4;
  localparam int BOOST_MAX = 12;

  function automatic logic [BOOST_W-1:0] clamp_boost(input logic [BOOST_W-1:0] s);
    return (s > BOOST_W'(BOOST_MAX)) ? BOOST_W'(BOOST_MAX) : s;
  endfunction

  function automatic logic [BOOST_W-1:0] boost_left(input logic [BOOST_W-1:0] s,
                                                     input logic [BOOST_W-1:0] cut);
    logic [BOOST_W-1:0] c;
    c = clamp_boost(s);
    return (cut >= c) ? '0 : BOOST_W'(c - cut);
  endfunction
endpackage

// File: rtl/lim_clip_detect.sv
module lim_clip_detect #(
  parameter int IN_W  = 28,
  parameter int OUT_W = 24,
  parameter int NCH   = 2
) (
  input  logic [NCH-1:0][IN_W-1:0] smp,
  output logic                     clip
);
  localparam int HI_W = IN_W - OUT_W + 1;
  logic [NCH-1:0] over;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [HI_W-1:0] hi;
      assign hi      = smp[c][IN_W-1:OUT_W-1];
      // sample fits the output range only when all headroom bits equal the sign
      assign over[c] = (|hi) && !(&hi);
    end
  endgenerate

  assign clip = |over;
endmodule

// File: rtl/lim_rate_timer.sv
module lim_rate_timer #(
  parameter int RATE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate,
  output logic              fire
);
  localparam int CNT_W = RATE_W + 1;
  localparam logic [CNT_W-1:0] SLOWEST = CNT_W'(1) << RATE_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, period, cnt_inc;

  always_comb begin
    period  = (rate == '0) ? SLOWEST : {1'b0, rate};
    cnt_inc = cnt_q + CNT_W'(1);
    fire    = tick && !clr && (cnt_inc >= period);
    cnt_d   = cnt_q;
    if (clr)        cnt_d = '0;
    else if (fire)  cnt_d = '0;
    else if (tick)  cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3 / R4: a firing step restarts the frame count
  a_r3_fire_restart: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == '0));
  // R4: the count holds between frames
  a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/lim_gain_state.sv
module lim_gain_state #(
  parameter int ATT_W   = 7,
  parameter int ATT_MAX = 96
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          step_dn,
  input  logic                          step_up,
  input  logic [lim_pkg::BOOST_W-1:0]   bass_set,
  input  logic [lim_pkg::BOOST_W-1:0]   treble_set,
  input  logic [ATT_W-1:0]              atten_set,
  output logic [lim_pkg::BOOST_W-1:0]   bass_eff,
  output logic [lim_pkg::BOOST_W-1:0]   treble_eff,
  output logic [ATT_W-1:0]              atten_eff
);
  import lim_pkg::*;
  localparam int SUM_W = ATT_W + 1;
  localparam logic [SUM_W-1:0] CEIL = SUM_W'(ATT_MAX);

  logic [BOOST_W-1:0] cut_b_q, cut_b_d, cut_t_q, cut_t_d;
  logic [ATT_W-1:0]   add_q, add_d;
  logic [SUM_W-1:0]   att_sum;
  logic               boost_left_any;

  always_comb begin
    bass_eff       = boost_left(bass_set, cut_b_q);
    treble_eff     = boost_left(treble_set, cut_t_q);
    boost_left_any = (bass_eff != '0) || (treble_eff != '0);
    att_sum        = {1'b0, atten_set} + {1'b0, add_q};
    atten_eff      = (att_sum > CEIL) ? ATT_W'(ATT_MAX) : att_sum[ATT_W-1:0];

    cut_b_d = cut_b_q;
    cut_t_d = cut_t_q;
    add_d   = add_q;
    if (clear) begin
      cut_b_d = '0;
      cut_t_d = '0;
      add_d   = '0;
    end else if (step_dn) begin
      if (boost_left_any) begin
        if (bass_eff   != '0) cut_b_d = cut_b_q + BOOST_W'(1);
        if (treble_eff != '0) cut_t_d = cut_t_q + BOOST_W'(1);
      end else if (att_sum < CEIL) begin
        add_d = add_q + ATT_W'(1);
      end
    end else if (step_up) begin
      if (add_q != '0) begin
        add_d = add_q - ATT_W'(1);
      end else begin
        if (cut_b_q != '0) cut_b_d = cut_b_q - BOOST_W'(1);
        if (cut_t_q != '0) cut_t_d = cut_t_q - BOOST_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cut_b_q <= '0;
      cut_t_q <= '0;
      add_q   <= '0;
    end else begin
      cut_b_q <= cut_b_d;
      cut_t_q <= cut_t_d;
      add_q   <= add_d;
    end
  end

  // R2: boost is given back before attenuation grows
  a_r2_boost_first: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !clear && boost_left_any) |=> (add_q == $past(add_q)));
  // R6: attenuation is removed before boost returns
  a_r6_atten_first: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !step_dn && !clear && add_q != '0) |=>
      (cut_b_q == $past(cut_b_q) && cut_t_q == $past(cut_t_q)));
  // R5: disable empties all reductions
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (add_q == '0 && cut_b_q == '0 && cut_t_q == '0));
  // R10: state moves only on a step or clear
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_dn && !step_up && !clear) |=>
      ($stable(add_q) && $stable(cut_b_q) && $stable(cut_t_q)));
  // R9: attenuation moves one dB per step
  a_r9_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (add_q != $past(add_q)) |->
      (add_q == $past(add_q) + ATT_W'(1) || add_q == $past(add_q) - ATT_W'(1) || add_q == '0));
endmodule

// File: rtl/peak_limiter.sv
module peak_limiter #(
  parameter int IN_W    = 28,
  parameter int OUT_W   = 24,
  parameter int RATE_W  = 7,
  parameter int ATT_W   = 7,
  parameter int ATT_MAX = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lim_en,
  input  logic              frame_stb,
  input  logic [IN_W-1:0]   smp_l,
  input  logic [IN_W-1:0]   smp_r,
  input  logic [3:0]        bass_set,
  input  logic [3:0]        treble_set,
  input  logic [ATT_W-1:0]  atten_set,
  input  logic [RATE_W-1:0] attack_rate,
  input  logic [RATE_W-1:0] release_rate,
  output logic [3:0]        bass_eff,
  output logic [3:0]        treble_eff,
  output logic [ATT_W-1:0]  atten_eff
);
  logic [1:0][IN_W-1:0] smp;
  logic clip, atk_tick, rel_tick, atk_clr, rel_clr, atk_fire, rel_fire, off;

  assign smp = {smp_r, smp_l};

  lim_clip_detect #(.IN_W(IN_W), .OUT_W(OUT_W), .NCH(2)) u_clip (
    .smp (smp),
    .clip(clip)
  );

  always_comb begin
    off      = !lim_en;
    atk_tick = frame_stb && lim_en && clip;
    rel_tick = frame_stb && lim_en && !clip;
    atk_clr  = off || rel_tick;
    rel_clr  = off || atk_tick;
  end

  lim_rate_timer #(.RATE_W(RATE_W)) u_attack (
    .clk(clk), .rst_n(rst_n), .clr(atk_clr), .tick(atk_tick),
    .rate(attack_rate), .fire(atk_fire)
  );

  lim_rate_timer #(.RATE_W(RATE_W)) u_release (
    .clk(clk), .rst_n(rst_n), .clr(rel_clr), .tick(rel_tick),
    .rate(release_rate), .fire(rel_fire)
  );

  lim_gain_state #(.ATT_W(ATT_W), .ATT_MAX(ATT_MAX)) u_gain (
    .clk(clk), .rst_n(rst_n), .clear(off),
    .step_dn(atk_fire), .step_up(rel_fire),
    .bass_set(bass_set), .treble_set(treble_set), .atten_set(atten_set),
    .bass_eff(bass_eff), .treble_eff(treble_eff), .atten_eff(atten_eff)
  );

  // R1 / R7: attack and release never step in the same frame
  a_r7_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(atk_fire && rel_fire));
  // R10: no step without a frame strobe
  a_r10_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
    (atk_fire || rel_fire) |-> frame_stb);
endmodule

// File: tb/tb_peak_limiter.sv
module tb_peak_limiter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lim_en, frame_stb;
  logic [27:0] smp_l, smp_r;
  logic [3:0]  bass_set, treble_set;
  logic [6:0]  atten_set, attack_rate, release_rate;
  logic [3:0]  bass_eff, treble_eff;
  logic [6:0]  atten_eff;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  peak_limiter dut (
    .clk(clk), .rst_n(rst_n), .lim_en(lim_en), .frame_stb(frame_stb),
    .smp_l(smp_l), .smp_r(smp_r), .bass_set(bass_set), .treble_set(treble_set),
    .atten_set(atten_set), .attack_rate(attack_rate), .release_rate(release_rate),
    .bass_eff(bass_eff), .treble_eff(treble_eff), .atten_eff(atten_eff)
  );

  localparam logic [27:0] POS_FS  = 28'h07FFFFF;
  localparam logic [27:0] POS_OV  = 28'h0800000;
  localparam logic [27:0] NEG_FS  = 28'hF800000;
  localparam logic [27:0] NEG_OV  = 28'hF7FFFFF;

  // {left, right, bass, treble, atten}; bass=2 treble=1 atten=3 attack=1 release=2
  localparam int NV = 15;
  localparam logic [70:0] TBL [NV] = '{
    {POS_FS, 28'h0,  4'd2, 4'd1, 7'd3},  // edge, no clip
    {POS_OV, 28'h0,  4'd1, 4'd0, 7'd3},  // left clip: boosts first
    {28'h0,  NEG_OV, 4'd0, 4'd0, 7'd3},  // right clip only
    {POS_OV, POS_OV, 4'd0, 4'd0, 7'd4},  // boosts gone: attenuation
    {NEG_OV, 28'h0,  4'd0, 4'd0, 7'd5},
    {28'h0,  NEG_FS, 4'd0, 4'd0, 7'd5},  // negative edge, release 1 of 2
    {28'h0,  28'h0,  4'd0, 4'd0, 7'd4},  // release: attenuation first
    {28'h0,  28'h0,  4'd0, 4'd0, 7'd4},
    {28'h0,  28'h0,  4'd0, 4'd0, 7'd3},
    {28'h0,  28'h0,  4'd0, 4'd0, 7'd3},
    {28'h0,  28'h0,  4'd1, 4'd1, 7'd3},  // then boosts
    {28'h0,  28'h0,  4'd1, 4'd1, 7'd3},
    {28'h0,  28'h0,  4'd2, 4'd1, 7'd3},
    {28'h0,  28'h0,  4'd2, 4'd1, 7'd3},  // never above settings
    {28'h0,  28'h0,  4'd2, 4'd1, 7'd3}
  };

  task automatic check(input string req, input logic [3:0] eb, input logic [3:0] et,
                       input logic [6:0] ea);
    checks++;
    if (bass_eff !== eb || treble_eff !== et || atten_eff !== ea) begin
      errors++;
      $display("FAIL %s: got b=%0d t=%0d a=%0d expected b=%0d t=%0d a=%0d",
               req, bass_eff, treble_eff, atten_eff, eb, et, ea);
    end
  endtask

  task automatic frame(input logic [27:0] l, input logic [27:0] r);
    @(negedge clk);
    smp_l = l; smp_r = r; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic clear_state();
    @(negedge clk); lim_en = 1'b0;
    @(negedge clk); lim_en = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lim_en = 1'b1; frame_stb = 1'b0;
    smp_l = '0; smp_r = '0;
    bass_set = 4'd2; treble_set = 4'd1; atten_set = 7'd3;
    attack_rate = 7'd1; release_rate = 7'd2;
    repeat (3) @(negedge clk);
    check("R11 reset", 4'd2, 4'd1, 7'd3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after release", 4'd2, 4'd1, 7'd3);

    // R1 R2 R3 R4 R6 R7 table walk
    for (int i = 0; i < NV; i++) begin
      frame(TBL[i][70:43], TBL[i][42:15]);
      check($sformatf("R1/R2/R4/R6/R7 vector %0d", i),
            TBL[i][14:11], TBL[i][10:7], TBL[i][6:0]);
    end

    // R10: clipping samples without a strobe change nothing
    @(negedge clk); smp_l = POS_OV; smp_r = NEG_OV;
    repeat (5) @(negedge clk);
    check("R10 no strobe", 4'd2, 4'd1, 7'd3);

    // R5: disable clears and ignores clips
    frame(POS_OV, 28'h0);
    check("R3 attack code 1", 4'd1, 4'd0, 7'd3);
    clear_state();
    check("R5 disable clears", 4'd2, 4'd1, 7'd3);
    @(negedge clk); lim_en = 1'b0;
    frame(POS_OV, POS_OV);
    check("R5 clip ignored while off", 4'd2, 4'd1, 7'd3);
    @(negedge clk); lim_en = 1'b1;

    // R8: boost above 12 acts as 12
    bass_set = 4'd15; treble_set = 4'd0;
    @(negedge clk);
    check("R8 clamp", 4'd12, 4'd0, 7'd3);
    frame(POS_OV, 28'h0);
    check("R8 reduce from clamp", 4'd11, 4'd0, 7'd3);
    clear_state();

    // R9: ceiling at 96
    bass_set = 4'd0; atten_set = 7'd95;
    frame(POS_OV, 28'h0);
    check("R9 step to ceiling", 4'd0, 4'd0, 7'd96);
    frame(POS_OV, 28'h0);
    frame(NEG_OV, 28'h0);
    check("R9 held at ceiling", 4'd0, 4'd0, 7'd96);
    clear_state();

    // R3: attack code 0 means 128 frames
    bass_set = 4'd1; atten_set = 7'd0; attack_rate = 7'd0;
    for (int k = 0; k < 127; k++) frame(POS_OV, 28'h0);
    check("R3 code 0 before 128", 4'd1, 4'd0, 7'd0);
    frame(POS_OV, 28'h0);
    check("R3 code 0 at 128", 4'd0, 4'd0, 7'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule